// File: doc/BRIEF.md
# Thermal Trip Shutdown with Stepped Current Foldback

This block decides what a backlight driver does when its die reaches the upper over-temperature limit. When the hot flag from an external comparator asserts during normal operation, it drops a single run signal. That signal gates both the boost converter and every LED current sink. The block also sends a one-cycle fault event to the latched fault indicator. Everything stays off until a separate cool-down flag reports that the die is back near 100 °C. Operation then resumes at a reduced DC current.

Each thermal trip lowers the restart current by one more step. A 2-bit scale code carries the current level to the current reference: 00 for full current, 01 for three quarters, 10 for half and 11 for one quarter. Once the code reaches one quarter it stays there. Only the enable input takes the block out of its active cycle. Dropping enable turns the outputs off and restores full current for the next start. All three inputs are asynchronous to the clock and pass through a synchronizer whose depth is a parameter.

Top module: `thermal_foldback`

## Requirements
- R1: While enable is low, or after reset, run_o is 0, scale_o is 00 and fault_o is 0.
- R2: With enable high and no hot flag, run_o goes to 1 within SYNC_STAGES+1 clock cycles and stays at 1.
- R3: A hot flag seen while running sets run_o to 0 on the following cycle, and fault_o pulses in that same cycle.
- R4: After a trip, run_o stays 0 until the cool flag is high and the hot flag is low at the same time. Run then resumes.
- R5: Each trip advances scale_o by one step. The codes are 00 for 100 %, 01 for 75 %, 10 for 50 % and 11 for 25 %.
- R6: At code 11, further trips leave scale_o at 11 and still report a fault.
- R7: Lowering enable clears scale_o to 00 from any state. A hot flag while disabled produces no fault event.
- R8: fault_o is high for exactly one cycle per trip. A hot flag held high through cool-down produces no further event and no further step.
- R9: scale_o changes only at a trip or on disable. While running with no trip, it is stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Driver enable, asynchronous |
| hot_i | input | 1 | Upper temperature threshold reached, asynchronous |
| cooled_i | input | 1 | Die cooled below restart temperature, asynchronous |
| run_o | output | 1 | Global run gate for boost and current sinks |
| scale_o | output | CODE_W | Restart current scale code |
| fault_o | output | 1 | One-cycle fault event toward the latched flag |

## Verification
On every cycle, the assertions check the cause-and-effect relations between the synchronized flags and the outputs. These cover the trip response and its fault pulse, the hold-off during cool-down, the step and saturation of the scale code, its stability while running, and the clearing on disable. The bench scenarios show what spans many cycles and what is seen only at the pins. That includes the full walk 00→01→10→11→11 across repeated trip and cool cycles, the count of fault events against the count of trips, the restart latency through the synchronizers, and the silence of the fault output when the hot flag rises while the block is disabled.

// File: rtl/tfb_pkg.sv
package tfb_pkg;

   typedef enum logic [1:0] {
      ST_OFF  = 2'd0,
      ST_RUN  = 2'd1,
      ST_COOL = 2'd2
   } tfb_state_e;

   function automatic logic [7:0] sat_inc(input logic [7:0] cur, input logic [7:0] top);
      return (cur >= top) ? top : cur + 8'd1;
   endfunction

endpackage

// File: rtl/tfb_sync.sv
module tfb_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
            end else begin
               pipe[0] <= d;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/tfb_ctrl.sv
module tfb_ctrl
   import tfb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic en_s,
   input  logic hot_s,
   input  logic cooled_s,
   output logic run,
   output logic cooling,
   output logic trip_step,
   output logic fault
);
   tfb_state_e st_q, st_d;

   always_comb begin
      st_d      = st_q;
      trip_step = 1'b0;
      if (!en_s) begin
         st_d = ST_OFF;
      end else begin
         case (st_q)
            ST_OFF:  st_d = ST_RUN;
            ST_RUN: begin
               if (hot_s) begin
                  st_d      = ST_COOL;
                  trip_step = 1'b1;
               end
            end
            ST_COOL: begin
               if (cooled_s && !hot_s) st_d = ST_RUN;
            end
            default: st_d = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_OFF;
         fault <= 1'b0;
      end else begin
         st_q  <= st_d;
         fault <= trip_step;
      end
   end

   assign run     = (st_q == ST_RUN);
   assign cooling = (st_q == ST_COOL);
endmodule

// File: rtl/tfb_scale.sv
module tfb_scale
   import tfb_pkg::*;
#(
   parameter int CODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_s,
   input  logic              step,
   output logic [CODE_W-1:0] code
);
   localparam logic [7:0] TOP = 8'((1 << CODE_W) - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= '0;
      end else if (!en_s) begin
         code <= '0;
      end else if (step) begin
         code <= CODE_W'(sat_inc(8'(code), TOP));
      end
   end
endmodule

// File: rtl/thermal_foldback.sv
module thermal_foldback #(
   parameter int SYNC_STAGES = 2,
   parameter int CODE_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              hot_i,
   input  logic              cooled_i,
   output logic              run_o,
   output logic [CODE_W-1:0] scale_o,
   output logic              fault_o
);
   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 8) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..8");
      end
      if (CODE_W < 1 || CODE_W > 7) begin : g_bad_code
         $error("CODE_W must lie in 1..7");
      end
   endgenerate

   localparam int NFLAG = 3;

   logic [NFLAG-1:0] raw, synced;
   logic en_s, hot_s, cooled_s;
   logic cooling, trip_step;

   assign raw = {cooled_i, hot_i, en_i};

   tfb_sync #(.STAGES(SYNC_STAGES), .W(NFLAG)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
   );

   assign en_s     = synced[0];
   assign hot_s    = synced[1];
   assign cooled_s = synced[2];

   tfb_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .en_s(en_s), .hot_s(hot_s), .cooled_s(cooled_s),
      .run(run_o), .cooling(cooling), .trip_step(trip_step), .fault(fault_o)
   );

   tfb_scale #(.CODE_W(CODE_W)) u_scale (
      .clk(clk), .rst_n(rst_n), .en_s(en_s), .step(trip_step), .code(scale_o)
   );
endmodule

// File: rtl/tfb_checker.sv
module tfb_checker #(
   parameter int CODE_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en_s,
   input logic              hot_s,
   input logic              cooled_s,
   input logic              cooling,
   input logic              run_o,
   input logic [CODE_W-1:0] scale_o,
   input logic              fault_o
);
   localparam logic [CODE_W-1:0] TOPC = '1;

   a_r1_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !en_s |=> (!run_o && scale_o == '0 && !fault_o));

   a_r3_trip_stops_run: assert property (@(posedge clk) disable iff (!rst_n)
      (run_o && hot_s && en_s) |=> (!run_o && fault_o));

   a_r4_hold_while_hot: assert property (@(posedge clk) disable iff (!rst_n)
      (cooling && !(cooled_s && !hot_s)) |=> !run_o);

   a_r5_step_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> (scale_o != $past(scale_o) || scale_o == TOPC));

   a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (scale_o == TOPC && en_s) |=> scale_o == TOPC);

   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |=> !fault_o);

   a_r9_stable_running: assert property (@(posedge clk) disable iff (!rst_n)
      (run_o && !hot_s && en_s) |=> $stable(scale_o));
endmodule

bind thermal_foldback tfb_checker #(.CODE_W(CODE_W)) u_tfb_checker (
   .clk(clk), .rst_n(rst_n), .en_s(en_s), .hot_s(hot_s), .cooled_s(cooled_s),
   .cooling(cooling), .run_o(run_o), .scale_o(scale_o), .fault_o(fault_o)
);

// File: tb/test_thermal_foldback.sv
module test_thermal_foldback;
   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, hot = 1'b0, cooled = 1'b0;
   logic run;
   logic [1:0] scale;
   logic fault;

   int checks = 0;
   int errors = 0;
   int fault_cnt = 0;
   int pulse_len = 0;
   int max_pulse = 0;

   typedef struct {
      logic       run;
      logic [1:0] scale;
      int         faults;
      string      req;
   } exp_t;

   exp_t sb_q[$];
   event chk_ev;

   always #(CLK_PERIOD/2) clk = ~clk;

   thermal_foldback i_thermal_foldback (
      .clk(clk), .rst_n(rst_n), .en_i(en), .hot_i(hot), .cooled_i(cooled),
      .run_o(run), .scale_o(scale), .fault_o(fault)
   );

   always @(negedge clk) begin
      if (fault) begin
         fault_cnt <= fault_cnt + 1;
         pulse_len <= pulse_len + 1;
         if (pulse_len + 1 > max_pulse) max_pulse <= pulse_len + 1;
      end else begin
         pulse_len <= 0;
      end
   end

   initial begin : monitor
      forever begin
         @(chk_ev);
         while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (run !== e.run || scale !== e.scale || fault_cnt != e.faults) begin
               errors++;
               $display("FAIL %s: run=%0b scale=%0b faults=%0d expected run=%0b scale=%0b faults=%0d",
                        e.req, run, scale, fault_cnt, e.run, e.scale, e.faults);
            end
         end
      end
   end

   task automatic drive(input logic e_v, input logic h_v, input logic c_v, input int cyc,
                        input logic x_run, input logic [1:0] x_scale, input int x_faults,
                        input string req);
      exp_t item;
      @(negedge clk);
      en = e_v; hot = h_v; cooled = c_v;
      repeat (cyc) @(negedge clk);
      #1;
      item.run = x_run; item.scale = x_scale; item.faults = x_faults; item.req = req;
      sb_q.push_back(item);
      -> chk_ev;
      #1;
   endtask

   task automatic trip_and_recover(input logic [1:0] x_scale, input int x_faults, input string req);
      drive(1, 1, 0, SETTLE, 0, x_scale, x_faults, req);
      drive(1, 0, 1, SETTLE, 1, x_scale, x_faults, req);
      drive(1, 0, 0, SETTLE, 1, x_scale, x_faults, req);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: run=%0b expected completion", run);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state with enable low
      drive(0, 0, 0, SETTLE, 0, 2'b00, 0, "R1");
      // R2: enable starts run at full scale within SYNC_STAGES+1 cycles
      drive(1, 0, 0, 3, 1, 2'b00, 0, "R2");
      drive(1, 0, 0, SETTLE, 1, 2'b00, 0, "R2");
      // R3 / R5: first trip -> off, 75 % code 01, one fault
      drive(1, 1, 0, SETTLE, 0, 2'b01, 1, "R3");
      // R8: hot held through cool-down: no extra step or event
      drive(1, 1, 0, 20, 0, 2'b01, 1, "R8");
      // R4: cool flag while still hot keeps run off
      drive(1, 1, 1, SETTLE, 0, 2'b01, 1, "R4");
      // R4: cool and not hot restarts at 75 %
      drive(1, 0, 1, SETTLE, 1, 2'b01, 1, "R4");
      drive(1, 0, 0, SETTLE, 1, 2'b01, 1, "R9");
      // R5: second and third trips -> 50 % then 25 %
      trip_and_recover(2'b10, 2, "R5");
      trip_and_recover(2'b11, 3, "R5");
      // R6: further trips saturate at 25 %
      trip_and_recover(2'b11, 4, "R6");
      trip_and_recover(2'b11, 5, "R6");
      // R9: running with no trip keeps the code
      drive(1, 0, 0, 30, 1, 2'b11, 5, "R9");
      // R7: disable clears the code
      drive(0, 0, 0, SETTLE, 0, 2'b00, 5, "R7");
      // R7: hot while disabled gives no fault
      drive(0, 1, 0, SETTLE, 0, 2'b00, 5, "R7");
      drive(0, 0, 0, SETTLE, 0, 2'b00, 5, "R7");
      // R2: re-enable restarts at full current
      drive(1, 0, 0, SETTLE, 1, 2'b00, 5, "R2");
      // R7: disable during cool-down clears state
      drive(1, 1, 0, SETTLE, 0, 2'b01, 6, "R7");
      drive(0, 1, 0, SETTLE, 0, 2'b00, 6, "R7");
      drive(1, 0, 0, SETTLE, 1, 2'b00, 6, "R7");
      // R8: every fault pulse lasted one cycle
      @(negedge clk);
      checks++;
      if (max_pulse != 1) begin
         errors++;
         $display("FAIL R8: longest fault pulse=%0d expected 1", max_pulse);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule